// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst SRAM

This block is a cycle-accurate, synthesizable model of a synchronous SRAM with flow-through reads. All control, address and byte-lane inputs are registered on the rising clock edge. A read word appears on the output in the cycle right after its command is registered. Write data arrives one cycle after its command. Because of that one-cycle lag, the shared data bus can carry a read on one cycle and write data on the next, with no idle cycle between them.

Each loaded address starts a four-beat burst. A single load/advance control either loads a fresh external address or steps a two-bit beat counter. The beat counter walks the low two address bits in one of two orders, and a level input selects the order. Linear order adds the beat count to the start bits modulo 4. Interleaved order XORs the start bits with the beat count.

Write data is held in a pending register for one cycle before it is committed to the array. A read that hits that pending word gets the merged new data. A hold input freezes the whole device. Three chip-select inputs can end a burst. An asynchronous active-low output enable gates the bus driver.

Top module: `zt_burst_sram`

## Requirements
- R1: After reset the bus driver is off and every array word reads as zero.
- R2: A read registered on a clock edge puts the addressed word on `rdata` with `rdata_drive` high, for the whole following cycle.
- R3: A write registered on edge k takes `wdata` on edge k+1. Lane i is bits [i*LANE_W +: LANE_W], and it is updated only when `lane_we_n[i]` was 0 on edge k. Lanes not selected keep their old contents.
- R4: A read of the same word, issued on the edge right after a write command, returns the new merged data with no idle cycle.
- R5: With `burst_interleave`=0, beat b of a burst uses low address bits (start+b) mod 4.
- R6: With `burst_interleave`=1, beat b uses low address bits start XOR b.
- R7: Advancing past the fourth beat wraps back to beat 0, so the counter runs modulo 4.
- R8: While `hold_req`=1, all synchronous inputs are ignored. State, the output word and its driver stay as they were, and a pending write waits for the next enabled edge to take its data.
- R9: A load (`new_cmd_n`=0) with any select inactive starts nothing and ends the burst. The bus is released in the next cycle, and a write beat already registered still completes.
- R10: The bus driver is off in the cycle after a write command is registered.
- R11: `out_en_n`=1 turns the driver off at once, with no clock edge needed.
- R12: An advance (`new_cmd_n`=1) while no burst is active leaves the device idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| hold_req | input | 1 | 1 freezes the device |
| new_cmd_n | input | 1 | 0 loads an address, 1 advances the burst |
| sel_a_n | input | 1 | Active-low select |
| sel_b | input | 1 | Active-high select |
| sel_c_n | input | 1 | Active-low select |
| write_n | input | 1 | 0 = write, 1 = read (sampled at load) |
| lane_we_n | input | LANES | Active-low byte-lane write selects |
| word_addr | input | AW | Word address |
| wdata | input | LANES*LANE_W | Write data, one cycle after its command |
| burst_interleave | input | 1 | Burst order select, level sensitive |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Read word (zero while not driven) |
| rdata_drive | output | 1 | Tri-state enable for the shared bus |

## Verification
A wrong burst counter or base address shows up as the wrong word on `rdata` in the very beat cycle where the address is used. The bench catches it because it compares each beat against known distinct data. A pending-write register that is lost, misaligned or wrongly masked shows up as stale or mixed lanes on the first read of that word. Reading right after the write means this appears within one cycle. A wrong driver state shows up on `rdata_drive` in the cycle after a write, a deselect or an output-enable change.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  // Low two address bits for a given beat of a burst.
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       interleave);
    logic [1:0] r;
    if (interleave) r = start ^ beat;
    else            r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/zt_burst_ctrl.sv
module zt_burst_ctrl
  import zt_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          new_cmd_n,
  input  logic          sel_ok,
  input  logic          write_n,
  input  logic [AW-1:0] word_addr,
  input  logic          interleave,
  output logic          active,
  output logic          is_wr,
  output logic [AW-1:0] cur_addr
);

  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;
  logic          active_q;
  logic          wr_q;

  // named events for the assertions
  logic load_ev, adv_ev, drop_ev;
  assign load_ev = en && !new_cmd_n && sel_ok;
  assign drop_ev = en && !new_cmd_n && !sel_ok;
  assign adv_ev  = en && new_cmd_n && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else if (load_ev) begin
      base_q   <= word_addr;
      beat_q   <= '0;
      active_q <= 1'b1;
      wr_q     <= !write_n;
    end else if (drop_ev) begin
      active_q <= 1'b0;
    end else if (adv_ev) begin
      beat_q   <= beat_q + 2'd1;
    end
  end

  assign active   = active_q;
  assign is_wr    = wr_q;
  assign cur_addr = {base_q[AW-1:2], beat_lo(base_q[1:0], beat_q, interleave)};

  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(active_q) && $stable(beat_q) && $stable(base_q) && $stable(wr_q)));

  a_r7_beat_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> (beat_q == $past(beat_q) + 2'd1));

  a_r9_deselect_ends: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> !active_q);

  a_r12_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (en && new_cmd_n && !active_q) |=> !active_q);

endmodule

// File: rtl/zt_write_pipe.sv
module zt_write_pipe #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wbeat,
  input  logic [AW-1:0]    beat_addr,
  input  logic [LANES-1:0] lane_we_n,
  input  logic [DW-1:0]    wdata,
  output logic             pend_valid,
  output logic [AW-1:0]    pend_addr,
  output logic [LANES-1:0] pend_mask,
  output logic [DW-1:0]    pend_data
);

  logic [LANES-1:0] mask_q;   // lane mask taken with the command

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_mask  <= '0;
      pend_data  <= '0;
    end else if (en) begin
      mask_q     <= ~lane_we_n;
      pend_valid <= wbeat;
      pend_addr  <= beat_addr;
      pend_mask  <= mask_q;
      pend_data  <= wdata;
    end
  end

  a_r9_pending_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wbeat) |=> (pend_valid && pend_addr == $past(beat_addr)));

  a_r8_pending_waits: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pend_valid) && $stable(pend_data)));

endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pend_valid,
  input  logic [AW-1:0]    pend_addr,
  input  logic [LANES-1:0] pend_mask,
  input  logic [DW-1:0]    pend_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_word
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] raw_word;
  logic          fwd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (en && pend_valid) begin
      for (int l = 0; l < LANES; l++)
        if (pend_mask[l]) mem_q[pend_addr][l*LANE_W +: LANE_W] <= pend_data[l*LANE_W +: LANE_W];
    end
  end

  assign raw_word = mem_q[rd_addr];
  assign fwd_hit  = pend_valid && (pend_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*LANE_W +: LANE_W] = (fwd_hit && pend_mask[g]) ?
      pend_data[g*LANE_W +: LANE_W] : raw_word[g*LANE_W +: LANE_W];
  end

  a_r4_commit_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pend_valid && pend_mask[0] && rd_addr == pend_addr) |=>
      (mem_q[$past(pend_addr)][LANE_W-1:0] == $past(pend_data[LANE_W-1:0])));

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_req,
  input  logic             new_cmd_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             write_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic [AW-1:0]    word_addr,
  input  logic [DW-1:0]    wdata,
  input  logic             burst_interleave,
  input  logic             out_en_n,
  output logic [DW-1:0]    rdata,
  output logic             rdata_drive
);

  logic          en, sel_ok;
  logic          active, is_wr;
  logic [AW-1:0] cur_addr;
  logic          pend_valid;
  logic [AW-1:0] pend_addr;
  logic [LANES-1:0] pend_mask;
  logic [DW-1:0] pend_data;
  logic [DW-1:0] rd_word;
  logic          rd_beat;

  assign en     = !hold_req;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  zt_burst_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .new_cmd_n(new_cmd_n),
    .sel_ok(sel_ok), .write_n(write_n), .word_addr(word_addr),
    .interleave(burst_interleave), .active(active), .is_wr(is_wr),
    .cur_addr(cur_addr)
  );

  zt_write_pipe #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_wpipe (
    .clk(clk), .rst_n(rst_n), .en(en), .wbeat(active && is_wr),
    .beat_addr(cur_addr), .lane_we_n(lane_we_n), .wdata(wdata),
    .pend_valid(pend_valid), .pend_addr(pend_addr),
    .pend_mask(pend_mask), .pend_data(pend_data)
  );

  zt_mem_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .en(en), .pend_valid(pend_valid),
    .pend_addr(pend_addr), .pend_mask(pend_mask), .pend_data(pend_data),
    .rd_addr(cur_addr), .rd_word(rd_word)
  );

  assign rd_beat     = active && !is_wr;
  assign rdata_drive = rd_beat && !out_en_n;
  assign rdata       = rdata_drive ? rd_word : '0;

  a_r10_write_release: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !new_cmd_n && sel_ok && !write_n) |=> !rdata_drive);

  a_r8_output_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !out_en_n && $past(!out_en_n)) |=> $stable(rdata_drive));

endmodule

// File: tb/zt_burst_sram_bench.sv
module zt_burst_sram_bench;
  localparam int AW = 6, LANES = 4, LANE_W = 9, DW = LANES * LANE_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hold_req = 0, new_cmd_n = 1, sel_a_n = 0, sel_b = 1, sel_c_n = 0, write_n = 1;
  logic [LANES-1:0] lane_we_n = '1;
  logic [AW-1:0] word_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic burst_interleave = 0, out_en_n = 0;
  logic [DW-1:0] rdata;
  logic rdata_drive;

  int checks = 0, fails = 0;

  // reference state
  logic [DW-1:0] ref_mem [1 << AW];
  logic m_act = 0, m_wr = 0, pw_valid = 0;
  logic [AW-1:0] m_base = '0, pw_addr = '0;
  logic [1:0] m_beat = 0;
  logic [LANES-1:0] pw_wen = '0;

  zt_burst_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_zt_burst_sram (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .new_cmd_n(new_cmd_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .write_n(write_n),
    .lane_we_n(lane_we_n), .word_addr(word_addr), .wdata(wdata),
    .burst_interleave(burst_interleave), .out_en_n(out_en_n),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    if (burst_interleave) lo = m_base[1:0] ^ m_beat;
    else lo = 2'((int'(m_base[1:0]) + int'(m_beat)) % 4);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive inputs, update reference on the edge, settle
  task automatic step(input logic ld_n, input logic wr_n, input int drop,
                      input logic [AW-1:0] a, input logic [LANES-1:0] bwn,
                      input logic [DW-1:0] d, input logic hold);
    new_cmd_n = ld_n; write_n = wr_n; word_addr = a; lane_we_n = bwn;
    wdata = d; hold_req = hold;
    sel_a_n = (drop == 1); sel_b = (drop != 2); sel_c_n = (drop == 3);
    @(posedge clk);
    if (!hold) begin
      if (pw_valid) begin
        for (int l = 0; l < LANES; l++)
          if (pw_wen[l]) ref_mem[pw_addr][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
        pw_valid = 0;
      end
      if (!ld_n) begin
        if (drop == 0) begin m_act = 1; m_wr = !wr_n; m_base = a; m_beat = 0; end
        else m_act = 0;
      end else if (m_act) m_beat = m_beat + 2'd1;
      if (m_act && m_wr) begin pw_valid = 1; pw_addr = model_addr(); pw_wen = ~bwn; end
    end
    #2;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(0, 1, 0, a, '1, d, 0);
  endtask
  task automatic wrc(input logic [AW-1:0] a, input logic [LANES-1:0] bwn, input logic [DW-1:0] d);
    step(0, 0, 0, a, bwn, d, 0);
  endtask
  task automatic adv(input logic [LANES-1:0] bwn, input logic [DW-1:0] d);
    step(1, 1, 0, '0, bwn, d, 0);
  endtask
  task automatic dsel(input int which, input logic [DW-1:0] d);
    step(0, 1, which, '0, '1, d, 0);
  endtask

  task automatic chk_read(input string tag);
    chk({tag, " drive"}, DW'(rdata_drive), DW'(m_act && !m_wr && !out_en_n));
    chk({tag, " data"}, rdata, (m_act && !m_wr && !out_en_n) ? ref_mem[model_addr()] : '0);
  endtask

  localparam logic [DW-1:0] DA = 36'h1_2345_6789, DB = 36'h2_AAAA_5555,
                            DC = 36'h3_0F0F_F0F0, DD = 36'h4_1111_2222;

  task automatic t_reset();
    chk("R1 drive after reset", DW'(rdata_drive), '0);
    rd(5, '0);
    chk("R1 zero word", rdata, '0);
    chk_read("R1");
  endtask

  task automatic t_write_read();
    wrc(3, '0, '0);
    chk("R10 released after write", DW'(rdata_drive), '0);
    rd(3, DA);
    chk("R4 forwarded word", rdata, DA);
    wrc(3, 4'b1010, '0);
    rd(3, DC);
    chk("R3 lane merge", rdata, {DA[35:27], DC[26:18], DA[17:9], DC[8:0]});
    rd(4, '0);
    chk("R2 other word", rdata, '0);
    chk_read("R2");
    wrc(30, '0, '0);
    rd(30, DB);
    chk("R4 read after write mix", rdata, DB);
    wrc(31, '0, '0);
    chk("R10 write after read", DW'(rdata_drive), '0);
    rd(31, DD);
    chk("R4 second mix", rdata, DD);
  endtask

  task automatic t_bursts();
    burst_interleave = 0;
    wrc(10, '0, '0); adv('0, DA); adv('0, DB); adv('0, DC);
    dsel(1, DD);
    chk("R9 released after deselect", DW'(rdata_drive), '0);
    rd(10, '0); chk("R5 beat0 addr10", rdata, DA);
    adv('1, '0); chk("R5 beat1 addr11", rdata, DB);
    adv('1, '0); chk("R5 beat2 addr8", rdata, DC);
    adv('1, '0); chk("R9 R5 beat3 addr9 pending done", rdata, DD);
    adv('1, '0); chk("R7 wrap to beat0", rdata, DA);
    burst_interleave = 1;
    rd(9, '0); chk("R6 beat0 addr9", rdata, DD);
    adv('1, '0); chk("R6 beat1 addr8", rdata, DC);
    adv('1, '0); chk("R6 beat2 addr11", rdata, DB);
    adv('1, '0); chk("R6 beat3 addr10", rdata, DA);
    chk_read("R6");
  endtask

  task automatic t_freeze();
    burst_interleave = 1;
    rd(11, '0); chk("R8 before hold", rdata, DB);
    step(0, 0, 0, 6'd0, '0, DC, 1);
    chk("R8 held data", rdata, DB);
    step(0, 0, 2, 6'd1, '0, DC, 1);
    chk("R8 held drive", DW'(rdata_drive), 1);
    adv('1, '0); chk("R8 resume beat1 addr10", rdata, DA);
    wrc(20, '0, '0);
    step(1, 1, 0, '0, '0, 36'hF_FFFF_FFFF, 1);
    dsel(0 + 3, DC);
    rd(20, '0); chk("R8 write data waits", rdata, DC);
  endtask

  task automatic t_deselect();
    burst_interleave = 0;
    rd(10, '0);
    dsel(2, '0); chk("R9 select b", DW'(rdata_drive), 0);
    adv('1, '0); chk("R12 idle advance", DW'(rdata_drive), 0);
    chk_read("R12");
    rd(10, '0); chk("R2 reload", rdata, DA);
    dsel(3, '0); chk("R9 select c", DW'(rdata_drive), 0);
  endtask

  task automatic t_oe();
    rd(11, '0);
    chk("R11 driven", DW'(rdata_drive), 1);
    out_en_n = 1; #1;
    chk("R11 async off", DW'(rdata_drive), 0);
    out_en_n = 0; #1;
    chk("R11 async on", rdata, DB);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_write_read();
    t_bursts();
    t_freeze();
    t_deselect();
    t_oe();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule